// File: doc/BRIEF.md
# Two-Register CPU Instruction Decoder

This block is the control front end of a small 8-bit CPU that has two general registers. It takes instruction bytes one at a time through a valid/ready handshake. It sorts each opcode byte into a class using its upper bits. For the classes that carry an address, it can wait for a second byte. It then presents one cycle of datapath controls, marked by `issue_o`. These controls are the ALU operation, the register selects and write enable, the immediate value, the memory strobes with the effective address, the I/O port strobes, the branch, skip and call requests, and the carry and halt requests.

The register file, the ALU, the program counter and the instruction memory are all outside this block. The block reads the two register values only to form indexed addresses. The parameter `EXT_FMT` selects the address format:

- With `EXT_FMT` set to 1 (the default), jump/call and load/store take two bytes and produce a 12-bit address.
- With `EXT_FMT` set to 0, every instruction is one byte and only the short address field is used.

Once a halt instruction issues, the block refuses further bytes until it is reset.

Top module: `insn_ctrl_dec`

## Requirements
- R1: A single-byte instruction accepted at a clock edge (`in_valid_i` and `in_ready_o` both high) raises `issue_o` with its controls for exactly the following cycle. With no new accept, `issue_o` is low in the cycle after that.
- R2: With `EXT_FMT`=1, a first byte whose bit 7 is 1 produces no issue. Its controls issue in the cycle after the second byte is accepted.
- R3: `cls_o` reports the class from the top bits of the first byte:
  - 0 when bits 7:6 are 00 (register-register)
  - 1 for 0100xxxx (backward branch)
  - 2 for 0101xxxx (skip)
  - 3 for 011xxxxx (load immediate)
  - 4 for 10xxxxxx (jump/call)
  - 5 for 11xxxxxx (load/store)
- R4: For a register-register instruction:
  - `alu_op_o` is bits 5:2, `dst_o` is bit 1 and `src_o` is bit 0.
  - `reg_we_o` is high for opcodes 0000 through 1010, 1100 and 1110, and low for 1011 (compare), 1101 and 1111.
- R5: Opcode 1100 raises `port_rd_o` and `reg_we_o`. Opcode 1101 raises `port_wr_o` only. For both, `port_sel_o` equals bit 0, and it is 0 for every other instruction.
- R6: Opcode 1111 decodes bits 1:0 as follows: 00 raises `set_c_o`, 01 raises `clr_c_o`, 10 raises `ret_o` and 11 raises `halt_o`. It never writes a register.
- R7: A backward branch 0100nnnn raises `back_o` with `imm_o` equal to -(n+1) in two's complement, that is {1111, ~nnnn}.
- R8: A skip 0101ccnn raises `skip_o` with `skip_cond_o`=cc and `skip_cnt_o`=nn.
- R9: A load immediate 011rnnnn sets `reg_we_o`=1, `imm_sel_o`=1 and `dst_o`=r, with `imm_o` equal to nnnn sign-extended to 8 bits.
- R10: Jump/call 10x?aaaa followed by byte B raises `jump_o` when x=0 or `call_o` when x=1, with `addr_o`={aaaa, B}.
- R11: Load/store 11xriaaa followed by byte B gives a base of {0, aaa, B}. When i=1 the base is added to the zero-extended register 1-r to form `addr_o`. When x=0 the outputs are `mem_rd_o`, `reg_we_o` and `dst_o`=r. When x=1 the outputs are `mem_wr_o` and `src_o`=r.
- R12: From the cycle in which a halt issues, `in_ready_o` is low and stays low until reset, so no later byte issues.
- R13: After reset, `issue_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_byte_i | input | 8 | Instruction byte |
| in_valid_i | input | 1 | Byte is offered |
| in_ready_o | output | 1 | Block can take a byte |
| reg0_i | input | 8 | Value of register 0, used for indexing |
| reg1_i | input | 8 | Value of register 1, used for indexing |
| issue_o | output | 1 | Controls are valid this cycle |
| cls_o | output | 3 | Instruction class |
| alu_op_o | output | 4 | ALU operation select |
| dst_o | output | 1 | Destination register |
| src_o | output | 1 | Source register |
| reg_we_o | output | 1 | Register write enable |
| imm_sel_o | output | 1 | Write the immediate instead of the ALU result |
| imm_o | output | 8 | Immediate value or branch offset |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_o | output | 12 | Effective address |
| port_sel_o | output | 1 | I/O port number |
| port_rd_o | output | 1 | Input port strobe |
| port_wr_o | output | 1 | Output port strobe |
| jump_o | output | 1 | Jump request |
| call_o | output | 1 | Call request |
| ret_o | output | 1 | Return request |
| back_o | output | 1 | Backward branch request |
| skip_o | output | 1 | Conditional skip request |
| skip_cond_o | output | 2 | Skip condition code |
| skip_cnt_o | output | 2 | Bytes to skip |
| set_c_o | output | 1 | Set carry |
| clr_c_o | output | 1 | Clear carry |
| halt_o | output | 1 | Halt request |

## Verification
The assertions rely on two properties of the inputs:
- `in_valid_i` is driven to a known level in every cycle after reset.
- Bytes are offered only through the handshake, so an issue always traces back to an accept one cycle earlier.

The register inputs are assumed stable during an issue cycle, because the address is formed from them combinationally. The stimulus changes every input only on the falling clock edge. It holds the register values constant across each instruction, and after the halt it keeps offering bytes so that the refusal is exercised.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [2:0] {
    CLS_RR   = 3'd0,
    CLS_BACK = 3'd1,
    CLS_SKIP = 3'd2,
    CLS_LDI  = 3'd3,
    CLS_JMP  = 3'd4,
    CLS_MEM  = 3'd5
  } cls_e;

  typedef struct packed {
    cls_e              cls;
    logic [OP_W-1:0]   alu_op;
    logic              dst;
    logic              src;
    logic              reg_we;
    logic              imm_sel;
    logic [BYTE_W-1:0] imm;
    logic              mem_rd;
    logic              mem_wr;
    logic              port_sel;
    logic              port_rd;
    logic              port_wr;
    logic              jump;
    logic              call;
    logic              ret;
    logic              back;
    logic              skip;
    logic [1:0]        skip_cond;
    logic [1:0]        skip_cnt;
    logic              set_c;
    logic              clr_c;
    logic              halt;
  } ctrl_t;
endpackage

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
  import insn_dec_pkg::*;
#(
  parameter bit EXT_FMT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              halt_now_i,
  output logic [BYTE_W-1:0] ins_o,
  output logic [BYTE_W-1:0] ext_o,
  output logic              issue_o
);
  logic              wait2_q, iss_q, halted_q;
  logic [BYTE_W-1:0] hold_q, ins_q, ext_q;
  logic              accept, two_byte;

  assign in_ready_o = ~halted_q & ~halt_now_i;
  assign accept     = in_valid_i & in_ready_o;
  // address-bearing classes have bit 7 set
  assign two_byte   = EXT_FMT & in_byte_i[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait2_q  <= 1'b0;
      iss_q    <= 1'b0;
      halted_q <= 1'b0;
      hold_q   <= '0;
      ins_q    <= '0;
      ext_q    <= '0;
    end else begin
      iss_q <= 1'b0;
      if (halt_now_i) halted_q <= 1'b1;
      if (accept) begin
        if (wait2_q) begin
          ins_q   <= hold_q;
          ext_q   <= in_byte_i;
          wait2_q <= 1'b0;
          iss_q   <= 1'b1;
        end else if (two_byte) begin
          hold_q  <= in_byte_i;
          wait2_q <= 1'b1;
        end else begin
          ins_q <= in_byte_i;
          ext_q <= '0;
          iss_q <= 1'b1;
        end
      end
    end
  end

  assign ins_o   = ins_q;
  assign ext_o   = ext_q;
  assign issue_o = iss_q;
endmodule

// File: rtl/insn_field_dec.sv
module insn_field_dec
  import insn_dec_pkg::*;
(
  input  logic              issue_i,
  input  logic [BYTE_W-1:0] ins_i,
  output ctrl_t             ctrl_o
);
  logic [OP_W-1:0] op;
  logic            d_bit, s_bit;
  logic            rr_we;

  assign op    = ins_i[5:2];
  assign d_bit = ins_i[1];
  assign s_bit = ins_i[0];

  always_comb begin
    unique case (op)
      4'hB, 4'hD, 4'hF: rr_we = 1'b0;
      default:          rr_we = 1'b1;
    endcase
  end

  always_comb begin
    ctrl_o     = '0;
    ctrl_o.cls = CLS_RR;
    unique casez (ins_i[7:4])
      4'b00??: begin
        ctrl_o.cls    = CLS_RR;
        ctrl_o.alu_op = op;
        ctrl_o.dst    = d_bit;
        ctrl_o.src    = s_bit;
        ctrl_o.reg_we = rr_we;
        if (op == 4'hC || op == 4'hD) ctrl_o.port_sel = s_bit;
        ctrl_o.port_rd = (op == 4'hC);
        ctrl_o.port_wr = (op == 4'hD);
        if (op == 4'hF) begin
          ctrl_o.set_c = (ins_i[1:0] == 2'b00);
          ctrl_o.clr_c = (ins_i[1:0] == 2'b01);
          ctrl_o.ret   = (ins_i[1:0] == 2'b10);
          ctrl_o.halt  = (ins_i[1:0] == 2'b11);
        end
      end
      4'b0100: begin
        ctrl_o.cls  = CLS_BACK;
        ctrl_o.back = 1'b1;
        ctrl_o.imm  = {4'hF, ~ins_i[3:0]};  // -(n+1)
      end
      4'b0101: begin
        ctrl_o.cls       = CLS_SKIP;
        ctrl_o.skip      = 1'b1;
        ctrl_o.skip_cond = ins_i[3:2];
        ctrl_o.skip_cnt  = ins_i[1:0];
      end
      4'b011?: begin
        ctrl_o.cls     = CLS_LDI;
        ctrl_o.dst     = ins_i[4];
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.imm_sel = 1'b1;
        ctrl_o.imm     = {{4{ins_i[3]}}, ins_i[3:0]};
      end
      4'b10??: begin
        ctrl_o.cls  = CLS_JMP;
        ctrl_o.jump = ~ins_i[5];
        ctrl_o.call = ins_i[5];
      end
      default: begin
        ctrl_o.cls    = CLS_MEM;
        ctrl_o.dst    = ins_i[4];
        ctrl_o.src    = ins_i[4];
        ctrl_o.reg_we = ~ins_i[5];
        ctrl_o.mem_rd = ~ins_i[5];
        ctrl_o.mem_wr = ins_i[5];
      end
    endcase
    if (!issue_i) ctrl_o = '0;
  end
endmodule

// File: rtl/insn_addr_gen.sv
module insn_addr_gen
  import insn_dec_pkg::*;
#(
  parameter bit EXT_FMT = 1'b1
) (
  input  logic              issue_i,
  input  logic [BYTE_W-1:0] ins_i,
  input  logic [BYTE_W-1:0] ext_i,
  input  logic [BYTE_W-1:0] reg0_i,
  input  logic [BYTE_W-1:0] reg1_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned IDX_PAD = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] base_jmp, base_mem;
  logic [BYTE_W-1:0] idx;
  logic              is_jmp, is_mem;

  assign is_jmp = (ins_i[7:6] == 2'b10);
  assign is_mem = (ins_i[7:6] == 2'b11);

  generate
    if (EXT_FMT) begin : g_ext
      assign base_jmp = {ins_i[3:0], ext_i};
      assign base_mem = {1'b0, ins_i[2:0], ext_i};
    end else begin : g_short
      logic unused_ext;
      assign unused_ext = ^ext_i;
      assign base_jmp   = {{(ADDR_W-4){1'b0}}, ins_i[3:0]};
      assign base_mem   = {{(ADDR_W-3){1'b0}}, ins_i[2:0]};
    end
  endgenerate

  // index by the register not named as data register
  assign idx = (is_mem && ins_i[3]) ? (ins_i[4] ? reg0_i : reg1_i) : '0;

  always_comb begin
    addr_o = '0;
    if (issue_i && is_jmp) addr_o = base_jmp;
    if (issue_i && is_mem) addr_o = base_mem + {{IDX_PAD{1'b0}}, idx};
  end
endmodule

// File: rtl/insn_ctrl_dec.sv
module insn_ctrl_dec
  import insn_dec_pkg::*;
#(
  parameter bit EXT_FMT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  in_byte_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [7:0]  reg0_i,
  input  logic [7:0]  reg1_i,
  output logic        issue_o,
  output logic [2:0]  cls_o,
  output logic [3:0]  alu_op_o,
  output logic        dst_o,
  output logic        src_o,
  output logic        reg_we_o,
  output logic        imm_sel_o,
  output logic [7:0]  imm_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [11:0] addr_o,
  output logic        port_sel_o,
  output logic        port_rd_o,
  output logic        port_wr_o,
  output logic        jump_o,
  output logic        call_o,
  output logic        ret_o,
  output logic        back_o,
  output logic        skip_o,
  output logic [1:0]  skip_cond_o,
  output logic [1:0]  skip_cnt_o,
  output logic        set_c_o,
  output logic        clr_c_o,
  output logic        halt_o
);
  logic [BYTE_W-1:0] ins, ext;
  logic              iss;
  ctrl_t             ctrl;

  insn_fetch_seq #(.EXT_FMT(EXT_FMT)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_byte_i  (in_byte_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .halt_now_i (ctrl.halt),
    .ins_o      (ins),
    .ext_o      (ext),
    .issue_o    (iss)
  );

  insn_field_dec u_dec (
    .issue_i (iss),
    .ins_i   (ins),
    .ctrl_o  (ctrl)
  );

  insn_addr_gen #(.EXT_FMT(EXT_FMT)) u_agen (
    .issue_i (iss),
    .ins_i   (ins),
    .ext_i   (ext),
    .reg0_i  (reg0_i),
    .reg1_i  (reg1_i),
    .addr_o  (addr_o)
  );

  assign issue_o     = iss;
  assign cls_o       = ctrl.cls;
  assign alu_op_o    = ctrl.alu_op;
  assign dst_o       = ctrl.dst;
  assign src_o       = ctrl.src;
  assign reg_we_o    = ctrl.reg_we;
  assign imm_sel_o   = ctrl.imm_sel;
  assign imm_o       = ctrl.imm;
  assign mem_rd_o    = ctrl.mem_rd;
  assign mem_wr_o    = ctrl.mem_wr;
  assign port_sel_o  = ctrl.port_sel;
  assign port_rd_o   = ctrl.port_rd;
  assign port_wr_o   = ctrl.port_wr;
  assign jump_o      = ctrl.jump;
  assign call_o      = ctrl.call;
  assign ret_o       = ctrl.ret;
  assign back_o      = ctrl.back;
  assign skip_o      = ctrl.skip;
  assign skip_cond_o = ctrl.skip_cond;
  assign skip_cnt_o  = ctrl.skip_cnt;
  assign set_c_o     = ctrl.set_c;
  assign clr_c_o     = ctrl.clr_c;
  assign halt_o      = ctrl.halt;
endmodule

// File: rtl/insn_dec_chk.sv
module insn_dec_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic issue_o,
  input logic reg_we_o,
  input logic mem_rd_o,
  input logic mem_wr_o,
  input logic port_rd_o,
  input logic port_wr_o,
  input logic jump_o,
  input logic call_o,
  input logic ret_o,
  input logic back_o,
  input logic skip_o,
  input logic halt_o
);
  // R1
  issue_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> $past(in_valid_i && in_ready_o));

  // R1
  strobe_needs_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || mem_rd_o || mem_wr_o || port_rd_o || port_wr_o) |-> issue_o);

  // R6
  flow_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({jump_o, call_o, ret_o, back_o, skip_o, halt_o}));

  // R11
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o) && !(mem_wr_o && reg_we_o));

  // R5
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_rd_o && port_wr_o) && !(port_wr_o && reg_we_o));

  // R12
  halt_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !in_ready_o);

  // R12
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && halt_o) |=> (!in_ready_o && !issue_o));
endmodule

bind insn_ctrl_dec insn_dec_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .issue_o    (issue_o),
  .reg_we_o   (reg_we_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .port_rd_o  (port_rd_o),
  .port_wr_o  (port_wr_o),
  .jump_o     (jump_o),
  .call_o     (call_o),
  .ret_o      (ret_o),
  .back_o     (back_o),
  .skip_o     (skip_o),
  .halt_o     (halt_o)
);

// File: tb/insn_ctrl_dec_tb.sv
module insn_ctrl_dec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {b1, b2, r0, r1, cls, mask(we,mrd,mwr,prd,pwr,jmp,call,skip,back,ret), val}
  localparam logic [56:0] VEC [NV] = '{
    {8'h07, 8'h00, 8'h00, 8'h00, 3'd0, 10'b1000000000, 12'h103}, // R4 adc
    {8'h2E, 8'h00, 8'h00, 8'h00, 3'd0, 10'b0000000000, 12'hB02}, // R4 cmp
    {8'h2B, 8'h00, 8'h00, 8'h00, 3'd0, 10'b1000000000, 12'hA03}, // R4 dec
    {8'h38, 8'h00, 8'h00, 8'h00, 3'd0, 10'b1000000000, 12'hE00}, // R4 mul
    {8'h31, 8'h00, 8'h00, 8'h00, 3'd0, 10'b1001000000, 12'hC81}, // R5 in
    {8'h36, 8'h00, 8'h00, 8'h00, 3'd0, 10'b0000100000, 12'hD02}, // R5 out
    {8'h3C, 8'h00, 8'h00, 8'h00, 3'd0, 10'b0000000000, 12'hF00}, // R6 setc
    {8'h3E, 8'h00, 8'h00, 8'h00, 3'd0, 10'b0000000001, 12'hF02}, // R6 ret
    {8'h45, 8'h00, 8'h00, 8'h00, 3'd1, 10'b0000000010, 12'h0FA}, // R7
    {8'h40, 8'h00, 8'h00, 8'h00, 3'd1, 10'b0000000010, 12'h0FF}, // R7
    {8'h5B, 8'h00, 8'h00, 8'h00, 3'd2, 10'b0000000100, 12'h00B}, // R8
    {8'h78, 8'h00, 8'h00, 8'h00, 3'd3, 10'b1000000000, 12'h1F8}, // R9
    {8'h67, 8'h00, 8'h00, 8'h00, 3'd3, 10'b1000000000, 12'h007}, // R9
    {8'h8A, 8'h34, 8'h00, 8'h00, 3'd4, 10'b0000010000, 12'hA34}, // R10 jump
    {8'hA3, 8'hFF, 8'h00, 8'h00, 3'd4, 10'b0000001000, 12'h3FF}, // R10 call
    {8'hC5, 8'h10, 8'h55, 8'h66, 3'd5, 10'b1100000000, 12'h510}, // R11 load
    {8'hEA, 8'hF0, 8'h11, 8'h20, 3'd5, 10'b0010000000, 12'h310}, // R11 st idx
    {8'hDF, 8'hFF, 8'hFF, 8'h07, 3'd5, 10'b1100000000, 12'h8FE}  // R11 ld idx
  };

  logic        clk, rst_n;
  logic [7:0]  in_byte, reg0, reg1;
  logic        in_valid;
  logic        in_ready, issue, dst, src, reg_we, imm_sel, mem_rd, mem_wr;
  logic [2:0]  cls;
  logic [3:0]  alu_op;
  logic [7:0]  imm;
  logic [11:0] addr;
  logic        port_sel, port_rd, port_wr, jump, call, ret, back, skip;
  logic [1:0]  skip_cond, skip_cnt;
  logic        set_c, clr_c, halt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  insn_ctrl_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_byte_i(in_byte), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .reg0_i(reg0), .reg1_i(reg1), .issue_o(issue),
    .cls_o(cls), .alu_op_o(alu_op), .dst_o(dst), .src_o(src), .reg_we_o(reg_we),
    .imm_sel_o(imm_sel), .imm_o(imm), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .addr_o(addr), .port_sel_o(port_sel), .port_rd_o(port_rd), .port_wr_o(port_wr),
    .jump_o(jump), .call_o(call), .ret_o(ret), .back_o(back), .skip_o(skip),
    .skip_cond_o(skip_cond), .skip_cnt_o(skip_cnt), .set_c_o(set_c),
    .clr_c_o(clr_c), .halt_o(halt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offer a byte for one edge; returns at the following negedge
  task automatic put(input logic [7:0] b);
    in_byte  = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [11:0] act_val(input logic [2:0] c);
    case (c)
      3'd0:       return {alu_op, port_sel, 5'b0, dst, src};
      3'd1:       return {4'b0, imm};
      3'd2:       return {8'b0, skip_cond, skip_cnt};
      3'd3:       return {3'b0, dst, imm};
      default:    return addr;
    endcase
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; reg0 = '0; reg1 = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 issue", {31'b0, issue}, 32'd0);
    chk("R13 ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 ready after release", {31'b0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      reg0 = VEC[i][40:33];
      reg1 = VEC[i][32:25];
      put(VEC[i][56:49]);
      if (VEC[i][56]) begin
        chk("R2 no issue after first byte", {31'b0, issue}, 32'd0);
        put(VEC[i][48:41]);
      end
      chk("R1 issue", {31'b0, issue}, 32'd1);
      chk("R3 class", {29'b0, cls}, {29'b0, VEC[i][24:22]});
      chk("R4-R11 strobes",
          {22'b0, reg_we, mem_rd, mem_wr, port_rd, port_wr, jump, call, skip, back, ret},
          {22'b0, VEC[i][21:12]});
      chk("R4-R11 fields", {20'b0, act_val(cls)}, {20'b0, VEC[i][11:0]});
      @(negedge clk);
      chk("R1 single-cycle issue", {31'b0, issue}, 32'd0);
    end

    // R9 immediate select and R11 register selects
    put(8'h67);
    chk("R9 imm_sel", {31'b0, imm_sel}, 32'd1);
    reg0 = 8'h00;
    put(8'hD0); put(8'h00);
    chk("R11 load dst", {31'b0, dst}, 32'd1);
    put(8'hF0); put(8'h00);
    chk("R11 store src", {31'b0, src}, 32'd1);
    chk("R11 store no we", {31'b0, reg_we}, 32'd0);

    // R6 carry sub-ops
    put(8'h3C);
    chk("R6 set carry", {30'b0, set_c, clr_c}, 32'd2);
    put(8'h3D);
    chk("R6 clear carry", {30'b0, set_c, clr_c}, 32'd1);
    chk("R6 no write", {31'b0, reg_we}, 32'd0);

    // R1 back-to-back issue
    in_byte = 8'h07; in_valid = 1'b1;
    @(negedge clk);
    chk("R1 b2b first", {31'b0, issue}, 32'd1);
    in_byte = 8'h45;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 b2b second", {31'b0, back}, 32'd1);

    // R12 halt
    put(8'h3F);
    chk("R12 halt issued", {31'b0, halt}, 32'd1);
    chk("R12 ready low at halt", {31'b0, in_ready}, 32'd0);
    in_byte = 8'h07; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 ready stays low", {31'b0, in_ready}, 32'd0);
    chk("R12 no issue after halt", {31'b0, issue}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 ready after re-reset", {31'b0, in_ready}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule